// File: doc/BRIEF.md
# Two-input ones-count modulo-4 detector

This block watches two single-bit inputs and keeps a running total of how many of them have been high, one sample per clock. The total is held modulo four. A flag output is high whenever that total is a whole multiple of four. On each rising clock edge the total grows by two when both inputs are high, by one when exactly one is high, and stays the same when both are low.

The flag depends only on the stored total. It is a Moore output: it changes one clock edge after the inputs that cause the change and never in between. A synchronous active-low reset returns the total to zero, so the flag reads high after reset. The block is meant as a small tally element. Its caller samples the flag to learn when the number of ones seen since reset is 0, 4, 8 and so on.

Top module: `ones_mod4_detect`

## Requirements
- R1: When `rst_n` is low at a rising clock edge, the running total becomes zero, so `out_z` is 1 after that edge.
- R2: When `in_x` and `in_y` are both 1 at a rising edge (both-high is decided before either-high), the total advances by 2 modulo 4.
- R3: When exactly one of `in_x` and `in_y` is 1 at a rising edge, the total advances by 1 modulo 4.
- R4: When both inputs are 0 at a rising edge, the total is unchanged, however many such edges occur.
- R5: `out_z` is 1 exactly when the number of 1s sampled since the last reset, modulo 4, equals 0. It changes only after a rising edge.
- R6: The total wraps correctly: from 3, one high input gives 0 (`out_z` = 1), and two high inputs give 1 (`out_z` = 0).
- R7: Reset has priority over the inputs: with both inputs held at 1 during reset, the total still becomes zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_x | input | 1 | First counted input bit |
| in_y | input | 1 | Second counted input bit |
| out_z | output | 1 | High while the total of ones modulo 4 is zero |

## Verification
Reset and counting can fall in the same cycle. If both inputs are high while `rst_n` is low, the add-two path and the clear path both act on one edge. The bench provokes this by holding both inputs at 1 through several reset edges, then releasing reset with the inputs still high. It judges the result by requiring `out_z` = 1 after the reset edges and the expected two-step progression (0, then 1) right after release. That shows the clear won and no increment leaked through.

// File: rtl/onescnt_pkg.sv
// Package: shared types for the ones-count modulo detector.
// Assumes a two-bit running total; the step width matches it.
package onescnt_pkg;
    localparam int CNT_W = 2;
    localparam int CNT_MOD = 1 << CNT_W;

    typedef logic [CNT_W-1:0] cnt_t;

    // Tally states; the code equals the total modulo four.
    typedef enum logic [CNT_W-1:0] {
        TALLY0 = 2'd0,
        TALLY1 = 2'd1,
        TALLY2 = 2'd2,
        TALLY3 = 2'd3
    } tally_state_t;
endpackage

// File: rtl/ones_step_sel.sv
// Module: ones_step_sel
// Turns the two input bits into an increment of 2, 1 or 0.
// The both-high test is made before the either-high test.
// Assumes the inputs are already synchronous to the clock.
module ones_step_sel
    import onescnt_pkg::*;
(
    input  logic bit_a,
    input  logic bit_b,
    output cnt_t step
);
    // Choose the increment: both high first, then either high.
    always_comb begin
        if (bit_a && bit_b)
            step = cnt_t'(2);
        else if (bit_a || bit_b)
            step = cnt_t'(1);
        else
            step = cnt_t'(0);
    end
endmodule

// File: rtl/tally_reg.sv
// Module: tally_reg
// Holds the running total modulo CNT_MOD. Adds the step every clock.
// Reset is synchronous and active low. Assumes step < CNT_MOD.
module tally_reg
    import onescnt_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  cnt_t         step,
    output tally_state_t state
);
    tally_state_t state_q;
    tally_state_t state_d;

    // Next total: the sum wraps in CNT_W bits.
    always_comb begin
        state_d = tally_state_t'(cnt_t'(state_q) + step);
    end

    // State register with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= TALLY0;
        else
            state_q <= state_d;
    end

    assign state = state_q;

    // R1: a reset edge leaves the zero state.
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (state_q == TALLY0));

    // R4: a zero step keeps the state.
    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step == cnt_t'(0)) |=> (state_q == $past(state_q)));

    // R6: from three, a single step wraps to zero.
    assert_wrap_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TALLY3 && step == cnt_t'(1)) |=> (state_q == TALLY0));

    // R6: from three, a double step wraps to one.
    assert_wrap_two_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TALLY3 && step == cnt_t'(2)) |=> (state_q == TALLY1));
endmodule

// File: rtl/ones_mod4_detect.sv
// Module: ones_mod4_detect (top)
// Counts the ones on in_x and in_y each clock, modulo four.
// out_z is high while the total is zero (Moore output).
// Assumes inputs are synchronous; reset is synchronous, active low.
module ones_mod4_detect
    import onescnt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_x,
    input  logic in_y,
    output logic out_z
);
    cnt_t         step;
    tally_state_t state;

    ones_step_sel u_step (
        .bit_a (in_x),
        .bit_b (in_y),
        .step  (step)
    );

    tally_reg u_tally (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (step),
        .state (state)
    );

    // Moore flag: decoded from the stored state only.
    always_comb begin
        out_z = (state == TALLY0);
    end

    // R2: both inputs high select the double step.
    assert_both_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_x && in_y) |-> (step == cnt_t'(2)));

    // R3: one input high selects the single step.
    assert_one_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_x ^ in_y) |-> (step == cnt_t'(1)));

    // R2: two double steps in a row bring the flag back to its earlier value.
    assert_double_pair_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_x && in_y) ##1 (in_x && in_y) |=> (out_z == $past(out_z, 2)));

    // R5: leaving the zero total with any one present clears the flag.
    assert_flag_leaves_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_z && (in_x || in_y)) |=> !out_z);

    // R4: the flag stays high while nothing is added.
    assert_flag_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_z && !in_x && !in_y) |=> out_z);
endmodule

// File: tb/ones_mod4_detect_bench.sv
module ones_mod4_detect_bench;
    logic clk = 1'b0;
    logic rst_n;
    logic in_x;
    logic in_y;
    logic out_z;

    int checks = 0;
    int errors = 0;
    int sw_ones = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    ones_mod4_detect u_ones_mod4_detect (
        .clk   (clk),
        .rst_n (rst_n),
        .in_x  (in_x),
        .in_y  (in_y),
        .out_z (out_z)
    );

    // Each entry is {x, y, expected z after the edge}, starting from total 0.
    localparam int NVEC = 17;
    localparam logic [2:0] VEC [NVEC] = '{
        3'b001, 3'b100, 3'b010, 3'b111, 3'b110, 3'b111, 3'b001, 3'b010,
        3'b000, 3'b110, 3'b101, 3'b010, 3'b010, 3'b010, 3'b110, 3'b100,
        3'b111
    };

    task automatic check(input logic got, input logic exp, input string req);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: out_z=%0b expected %0b at %0t", req, got, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // One counted clock: drive at negedge, sample at the next negedge.
    task automatic step_and_check(input logic x, input logic y, input string req);
        in_x = x;
        in_y = y;
        tick();
        sw_ones += int'(x) + int'(y);
        check(out_z, ((sw_ones % 4) == 0), req);
    endtask

    initial begin
        rst_n = 1'b0;
        in_x = 1'b0;
        in_y = 1'b0;
        @(negedge clk);
        tick();
        tick();
        check(out_z, 1'b1, "R1");
        rst_n = 1'b1;
        sw_ones = 0;

        // Vector table walk
        for (int i = 0; i < NVEC; i++) begin
            string tag;
            logic vz;
            in_x = VEC[i][2];
            in_y = VEC[i][1];
            vz = VEC[i][0];
            if (in_x && in_y) tag = "R2";
            else if (in_x || in_y) tag = "R3";
            else tag = "R4";
            tick();
            sw_ones += int'(VEC[i][2]) + int'(VEC[i][1]);
            check(out_z, vz, tag);
            check(out_z, ((sw_ones % 4) == 0), "R5");
        end

        // R7: reset and double step in the same cycles
        in_x = 1'b1;
        in_y = 1'b1;
        rst_n = 1'b0;
        tick();
        tick();
        tick();
        check(out_z, 1'b1, "R7");
        rst_n = 1'b1;
        sw_ones = 0;
        step_and_check(1'b1, 1'b1, "R7");
        step_and_check(1'b1, 1'b1, "R2");

        // R4: long idle stretch at a nonzero total
        step_and_check(1'b0, 1'b1, "R3");
        for (int i = 0; i < 20; i++) step_and_check(1'b0, 1'b0, "R4");
        step_and_check(1'b1, 1'b1, "R6");
        step_and_check(1'b1, 1'b0, "R6");
        step_and_check(1'b1, 1'b1, "R2");
        step_and_check(1'b0, 1'b1, "R3");
        step_and_check(1'b1, 1'b1, "R6");

        // R1: reset from the middle of a count
        step_and_check(1'b1, 1'b0, "R3");
        in_x = 1'b0;
        in_y = 1'b0;
        rst_n = 1'b0;
        tick();
        check(out_z, 1'b1, "R1");
        rst_n = 1'b1;
        sw_ones = 0;

        // R5: pseudo-random stream against the software count
        begin
            logic [7:0] lfsr;
            lfsr = 8'hA5;
            for (int i = 0; i < 300; i++) begin
                lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
                step_and_check(lfsr[0], lfsr[3], "R5");
            end
        end

        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #100000;
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, got timeout expected finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule